// File: doc/BRIEF.md
# Single-Cycle Load/Store Datapath Core

This block is a 32-bit processor core that executes one instruction per clock. The current program counter selects a word of instruction memory. The decoder turns that word into control for a register file, an ALU and a data memory. At the next rising edge the program counter, the register file and the data memory all take their new values together. Seven operations are understood: word load, word store, add, subtract, bitwise OR, signed set-less-than and branch-on-equal. Every other encoding only moves the program counter on.

Both memories are filled through one load port while reset is held. Data memory keeps its contents across a reset. A combinational peek port for registers and one for data memory show the architectural state, so a test environment can compare it after each instruction.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears all 32 registers. Memory contents are kept across a reset.
- R2: When `ld_we` is high while `rst` is high, `ld_data` is written to word `ld_addr`. The target is data memory if `ld_dmem` is 1 and instruction memory if it is 0. When `rst` is low, the load port has no effect.
- R3: The instruction is the word at index `pc[9:2]` of instruction memory. Every instruction except a taken branch advances `pc` by 4 at the clock edge that ends it.
- R4: Opcode 0 (bits 31:26) with function field (bits 5:0) 0x20, 0x22 or 0x25 writes rs+rt, rs−rt or rs|rt into register rd. rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11.
- R5: Opcode 0 with function 0x2A writes 1 into rd when rs is less than rt as signed numbers, and 0 otherwise.
- R6: Opcode 0x23 writes into register rt the data word at index bits [9:2] of rs plus the sign-extended immediate (bits 15:0).
- R7: Opcode 0x2B writes register rt into the data word addressed as in R6.
- R8: Opcode 0x04 sets `pc` to pc+4 plus the sign-extended immediate shifted left by 2 when rs equals rt. Otherwise it sets `pc` to pc+4.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: An unknown opcode, or opcode 0 with an unknown function, changes no register and no memory word.
- R11: Each instruction changes at most one thing besides `pc`. A store leaves every register unchanged, and a load leaves every memory word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write strobe, honoured only during reset |
| ld_dmem | input | 1 | Load target: 1 = data memory, 0 = instruction memory |
| ld_addr | input | AW (8) | Word index for the load port |
| ld_data | input | 32 | Word written through the load port |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_val | output | 32 | Current value of register `peek_reg` |
| peek_mem | input | AW (8) | Data-memory word index to observe |
| peek_mem_val | output | 32 | Current value of data word `peek_mem` |
| pc | output | 32 | Program counter (byte address) |

## Verification
A directed program runs first. It loads 3 and 42, adds them to 45 and stores the result. Each ALU function gets the same operand pair, so an operation swapped for another gives a different value. The set-less-than test uses a negative operand in both orders, which separates a signed compare from an unsigned one. Further cases cover a write aimed at register 0, an unknown opcode, an unknown function code, a load-port write while running, an untaken branch, a taken forward branch and a backward branch to itself. These show whether the gating of register writes, memory writes and branch selection is correct. A second reset at the end shows that registers clear while data memory keeps its contents.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic          ld_dmem,
  input  logic [AW-1:0] ld_addr,
  input  logic [31:0]   ld_data,
  input  logic [4:0]    peek_reg,
  output logic [31:0]   peek_reg_val,
  input  logic [AW-1:0] peek_mem,
  output logic [31:0]   peek_mem_val,
  output logic [31:0]   pc
);
  localparam int DEPTH = 1 << AW;
  localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B, OP_BEQ = 6'h04;
  localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_OR = 6'h25, FN_SLT = 6'h2A;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR, ALU_SLT} alu_t;

  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] rf   [32];

  logic [31:0] inst, rs_val, rt_val, imm_ext, alu_b, alu_y, rd_word, wdata;
  logic [31:0] pc_plus4, pc_next;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, wsel;
  logic        rf_we, dm_we, dm_re, is_beq, zero;
  alu_t        aluf;
  logic        unused_bits;

  assign inst    = imem[pc[AW+1:2]];
  assign op      = inst[31:26];
  assign rs      = inst[25:21];
  assign rt      = inst[20:16];
  assign rd      = inst[15:11];
  assign funct   = inst[5:0];
  assign imm_ext = {{16{inst[15]}}, inst[15:0]};
  assign rs_val  = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val  = (rt == 5'd0) ? 32'd0 : rf[rt];

  always_comb begin
    rf_we  = 1'b0;
    dm_we  = 1'b0;
    dm_re  = 1'b0;
    is_beq = 1'b0;
    wsel   = rd;
    alu_b  = rt_val;
    aluf   = ALU_ADD;
    case (op)
      OP_R: begin
        case (funct)
          FN_ADD: begin rf_we = 1'b1; aluf = ALU_ADD; end
          FN_SUB: begin rf_we = 1'b1; aluf = ALU_SUB; end
          FN_OR:  begin rf_we = 1'b1; aluf = ALU_OR;  end
          FN_SLT: begin rf_we = 1'b1; aluf = ALU_SLT; end
          default: ;
        endcase
      end
      OP_LW: begin rf_we = 1'b1; dm_re = 1'b1; wsel = rt; alu_b = imm_ext; end
      OP_SW: begin dm_we = 1'b1; alu_b = imm_ext; end
      OP_BEQ: begin is_beq = 1'b1; aluf = ALU_SUB; end
      default: ;
    endcase
  end

  always_comb begin
    case (aluf)
      ALU_ADD: alu_y = rs_val + alu_b;
      ALU_SUB: alu_y = rs_val - alu_b;
      ALU_OR:  alu_y = rs_val | alu_b;
      default: alu_y = {31'd0, $signed(rs_val) < $signed(alu_b)};
    endcase
  end

  assign zero     = (alu_y == 32'd0);
  assign rd_word  = dm_re ? dmem[alu_y[AW+1:2]] : 32'd0;
  assign wdata    = dm_re ? rd_word : alu_y;
  assign pc_plus4 = pc + 32'd4;
  assign pc_next  = (is_beq && zero) ? pc_plus4 + {imm_ext[29:0], 2'b00} : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      pc <= pc_next;
      if (rf_we && wsel != 5'd0) rf[wsel] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && ld_we && !ld_dmem) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_we && ld_dmem) dmem[ld_addr] <= ld_data;
    end else if (dm_we) begin
      dmem[alu_y[AW+1:2]] <= rt_val;
    end
  end

  assign peek_reg_val = rf[peek_reg];
  assign peek_mem_val = dmem[peek_mem];
  assign unused_bits  = ^{inst[10:6], alu_y[31:AW+2], alu_y[1:0]};
endmodule

module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [5:0]  op,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] imm_ext,
  input logic [4:0]  peek_reg,
  input logic [31:0] peek_reg_val
);
  // R1
  pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == 32'd0);

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h04) |=> pc == $past(pc) + 32'd4);

  // R8
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val == rt_val) |=> pc == $past(pc) + 32'd4 + {$past(imm_ext[29:0]), 2'b00});

  // R8
  beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

  // R9
  r0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (peek_reg == 5'd0) |-> peek_reg_val == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .op(op), .rs_val(rs_val), .rt_val(rt_val),
  .imm_ext(imm_ext), .peek_reg(peek_reg), .peek_reg_val(peek_reg_val)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0, ld_dmem = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  peek_reg = '0;
  logic [7:0]  peek_mem = '0;
  logic [31:0] peek_reg_val, peek_mem_val, pc;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .peek_reg(peek_reg), .peek_reg_val(peek_reg_val),
    .peek_mem(peek_mem), .peek_mem_val(peek_mem_val), .pc(pc)
  );

  function automatic logic [31:0] rtype(input int s, input int t, input int d, input logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] o, input int s, input int t, input logic [15:0] im);
    return {o, 5'(s), 5'(t), im};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic chk_reg(input string req, input int r, input logic [31:0] exp);
    peek_reg = 5'(r); #1;
    check(req, peek_reg_val, exp);
  endtask
  task automatic chk_mem(input string req, input int a, input logic [31:0] exp);
    peek_mem = 8'(a); #1;
    check(req, peek_mem_val, exp);
  endtask
  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic load(input logic dm, input int a, input logic [31:0] d);
    ld_we = 1'b1; ld_dmem = dm; ld_addr = 8'(a); ld_data = d;
    step();
    ld_we = 1'b0;
  endtask

  task automatic t_reset_and_load();
    step(); step();
    check("R1 pc", pc, 32'd0);
    chk_reg("R1 r9", 9, 0);
    load(1, 0, 32'd3); load(1, 1, 32'd42); load(1, 2, 32'hFFFF_FFFB); load(1, 3, 32'd0);
    load(0, 0, itype(6'h23, 0, 9, 16'd0));
    load(0, 1, itype(6'h23, 0, 8, 16'd4));
    load(0, 2, rtype(9, 8, 10, 6'h20));
    load(0, 3, itype(6'h2B, 0, 10, 16'd12));
    load(0, 4, rtype(9, 8, 11, 6'h22));
    load(0, 5, rtype(9, 8, 12, 6'h25));
    load(0, 6, itype(6'h23, 0, 13, 16'd8));
    load(0, 7, rtype(13, 9, 14, 6'h2A));
    load(0, 8, rtype(9, 13, 15, 6'h2A));
    load(0, 9, rtype(9, 8, 0, 6'h20));
    load(0, 10, 32'hFFFF_FFFF);
    load(0, 11, rtype(9, 8, 16, 6'h3F));
    load(0, 12, itype(6'h04, 9, 8, 16'd5));
    load(0, 13, itype(6'h04, 10, 10, 16'd2));
    load(0, 14, rtype(9, 9, 17, 6'h20));
    load(0, 15, rtype(9, 9, 17, 6'h20));
    load(0, 16, itype(6'h04, 0, 0, 16'hFFFF));
    chk_mem("R2 dmem load", 1, 32'd42);
    check("R1 pc held in reset", pc, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_load_store();
    step(); check("R3 pc", pc, 32'd4);  chk_reg("R6 lw r9", 9, 32'd3);
    chk_mem("R11 lw keeps mem", 0, 32'd3);
    step(); check("R3 pc", pc, 32'd8);  chk_reg("R6 lw r8", 8, 32'd42);
    step(); check("R3 pc", pc, 32'd12); chk_reg("R4 add", 10, 32'd45);
    step(); check("R3 pc", pc, 32'd16); chk_mem("R7 sw", 3, 32'd45);
    chk_reg("R11 sw keeps regs", 10, 32'd45);
  endtask

  task automatic t_alu();
    step(); chk_reg("R4 sub", 11, 32'hFFFF_FFD9);
    step(); chk_reg("R4 or", 12, 32'd43);
    step(); chk_reg("R6 lw negative", 13, 32'hFFFF_FFFB);
    step(); chk_reg("R5 slt signed true", 14, 32'd1);
    step(); chk_reg("R5 slt signed false", 15, 32'd0);
    check("R3 pc", pc, 32'd36);
  endtask

  task automatic t_reg0_and_noops();
    step(); chk_reg("R9 r0 write dropped", 0, 32'd0);
    ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = 8'd0; ld_data = 32'd99;
    step();
    ld_we = 1'b0;
    chk_reg("R10 unknown opcode", 31, 32'd0);
    chk_mem("R2 load ignored when running", 0, 32'd3);
    check("R10 pc", pc, 32'd44);
    step(); chk_reg("R10 unknown funct", 16, 32'd0);
    check("R10 pc", pc, 32'd48);
  endtask

  task automatic t_branch();
    step(); check("R8 beq not taken", pc, 32'd52);
    step(); check("R8 beq taken forward", pc, 32'd64);
    chk_reg("R8 skipped instr", 17, 32'd0);
    step(); check("R8 beq backward self", pc, 32'd64);
    step(); check("R8 beq backward self", pc, 32'd64);
  endtask

  task automatic t_rereset();
    rst = 1'b1;
    step();
    check("R1 pc re-reset", pc, 32'd0);
    chk_reg("R1 regs cleared", 9, 32'd0);
    chk_mem("R1 memory kept", 3, 32'd45);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset_and_load();
    t_load_store();
    t_alu();
    t_reg0_and_noops();
    t_branch();
    t_rereset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule